// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block drives the transmit side of a serial audio port in clock-master mode. It derives a bit-clock enable from the system clock with a programmable divider. It counts bit periods through a time-division-multiplexed frame and produces, one register stage after each bit-clock enable, the frame sync level, the serial data bit and the data output enable. The frame is cut into slots. Each slot is 16 bits, 32 bits, or as wide as the sample. A 16-bit mask chooses which slots carry audio, and slots past the configured count stay silent.

Audio samples arrive on a valid/ready stream, one sample for every enabled slot. The block holds no sample buffer, so the back-pressure rules are strict. `s_ready` is high for exactly one system clock: the bit-clock-enable cycle that opens an enabled slot. The sample must already be on `s_data` with `s_valid` high in that cycle. The upstream side must keep `s_valid` and `s_data` stable until the handshake. If `s_valid` is low at that moment, the slot carries zeros, the sample is not retried, and a sticky underrun flag is set. While mute is on, the stream is not consumed at all.

All `cfg_*` inputs except the two mute controls must be stable while `enable` is high. They are changed while the block is disabled. The mute controls take effect at the start of the next enabled slot.

Top module: `tdm_frame_tx`

## Requirements
- R1: While `enable` is high, `bclk_en` is high for one clock in every `cfg_bclk_div`+1 clocks. The first pulse comes `cfg_bclk_div`+1 clocks after `enable` rises. `bclk_en` stays low while `enable` is low.
- R2: The first bit-clock enable after `enable` rises starts bit position 0 of a frame. Each later enable advances the position by one, wrapping to 0 after position `cfg_frame_len_m1`, so a frame is `cfg_frame_len_m1`+1 bit periods. Outputs for a position appear on the clock after its `bclk_en` cycle.
- R3: With `cfg_fs_chan_id`=0 and `cfg_fs_early`=0, frame sync is active for positions 0 to `cfg_fs_width_m1`. Active level is high when `cfg_fs_active_high`=1 and low when it is 0. Sync is at its inactive level at every other position.
- R4: With `cfg_fs_chan_id`=1, the active window is the first floor(L/2) positions of the frame, where L is the frame length, and `cfg_fs_width_m1` is ignored.
- R5: With `cfg_fs_early`=1, sync at position p takes the level that position p+1 (mod L) would have, so it leads the frame by one bit period.
- R6: The slot width is set by `cfg_slot_size`: 0 means the data size, 1 means 16, and 2 or 3 mean 32. The data size is set by `cfg_data_size`: 0 means 8, 1 means 10, 2 means 16, 3 means 20, 4 means 24, and any other value means 32. Slot s starts at position s times the slot width. It is enabled when s ≤ `cfg_slot_cnt_m1` and mask bit s is 1. In an enabled slot, sample bit k goes out at slot bit `cfg_first_bit`+k for k below the data size, and only while that falls inside the slot. Every other bit of an enabled slot is 0.
- R7: With `cfg_msb_first`=0, bit k of the sample is sent first, starting at k=0 (least significant bit first). With `cfg_msb_first`=1, bit (data size − 1 − k) is sent first (most significant bit first).
- R8: `s_ready` is high only in the `bclk_en` cycle that opens an enabled slot while mute is off. The sample present in that cycle is the one transmitted in that slot.
- R9: `sd_oe` is 1 throughout enabled slots. In disabled or out-of-count slots it is 0 when `cfg_tristate_idle`=1 and 1 otherwise. `sd_out` is 0 whenever `sd_oe` is 0.
- R10: With `cfg_mute`=1, each enabled slot sends zeros (`cfg_mute_last`=0) or the last sample taken before mute (`cfg_mute_last`=1). No samples are consumed and no underrun is raised.
- R11: An enabled slot that opens with mute off and `s_valid` low sends zeros and sets `underrun`. `underrun` stays set until a clock with `underrun_clr`=1 and no new underrun.
- R12: After reset, and on the clock after `enable` falls, `sd_out` and `sd_oe` are 0 and frame sync is at its inactive level. Right after reset `fs_out` is 1 and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the frame engine |
| cfg_bclk_div | input | 8 | Bit-clock divider minus one |
| cfg_frame_len_m1 | input | 8 | Frame length in bit periods minus one |
| cfg_fs_width_m1 | input | 7 | Sync active width minus one |
| cfg_fs_early | input | 1 | Sync leads the frame by one bit |
| cfg_fs_active_high | input | 1 | Sync active level is high |
| cfg_fs_chan_id | input | 1 | Sync marks the first half of the frame |
| cfg_slot_cnt_m1 | input | 4 | Slot count minus one |
| cfg_slot_mask | input | 16 | Enable bit per slot |
| cfg_slot_size | input | 2 | Slot width code |
| cfg_data_size | input | 3 | Sample width code |
| cfg_first_bit | input | 5 | Data start bit inside each slot |
| cfg_msb_first | input | 1 | Most significant bit first |
| cfg_tristate_idle | input | 1 | Release the line in silent slots |
| cfg_mute | input | 1 | Mute enabled slots |
| cfg_mute_last | input | 1 | Mute repeats last sample instead of zeros |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample taken this cycle |
| s_data | input | 32 | Sample, right aligned |
| underrun_clr | input | 1 | Clear the underrun flag |
| bclk_en | output | 1 | Bit-clock enable |
| fs_out | output | 1 | Frame sync |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A wrong position or slot counter shows up on the clock after the next bit-clock enable. The sync edge falls at the wrong bit, or the data bit or output enable takes the value of the wrong slot. A fault in the sample register or the last-sample register corrupts the data bits of the very next enabled slot. A handshake fault shows as `s_ready` in a cycle that does not open an enabled slot, so a sample is lost or repeated, or `underrun` rises when it should not. Comparing every port against a frame model on every clock therefore catches each of these within one bit period of the first wrong decision.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  // sample width in bits for a data size code
  function automatic logic [5:0] data_bits(input logic [2:0] code);
    case (code)
      3'd0:    data_bits = 6'd8;
      3'd1:    data_bits = 6'd10;
      3'd2:    data_bits = 6'd16;
      3'd3:    data_bits = 6'd20;
      3'd4:    data_bits = 6'd24;
      default: data_bits = 6'd32;
    endcase
  endfunction

  // slot width in bits for a slot size code
  function automatic logic [5:0] slot_bits(input logic [1:0] sz, input logic [2:0] ds);
    case (sz)
      2'd0:    slot_bits = data_bits(ds);
      2'd1:    slot_bits = 6'd16;
      default: slot_bits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_tx_bclk.sv
module tdm_tx_bclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             bclk_en
);
  logic [DIV_W-1:0] cnt;

  assign bclk_en = enable && (cnt == cfg_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (bclk_en) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_BCLK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |=> (cfg_div == '0 || !bclk_en)); // R1

  AST_BCLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !bclk_en); // R1
endmodule

// File: rtl/tdm_tx_timer.sv
module tdm_tx_timer
  import tdm_tx_pkg::*;
#(
  parameter int FRM_W = 8,
  parameter int FSW_W = 7,
  parameter int SLOTS = 16,
  parameter int BIS_W = 5,
  parameter int SIW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [FRM_W-1:0] cfg_frame_len_m1,
  input  logic [FSW_W-1:0] cfg_fs_width_m1,
  input  logic             cfg_fs_early,
  input  logic             cfg_fs_active_high,
  input  logic             cfg_fs_chan_id,
  input  logic [1:0]       cfg_slot_size,
  input  logic [2:0]       cfg_data_size,
  output logic [FRM_W-1:0] nx_pos,
  output logic [BIS_W-1:0] nx_bis,
  output logic [SIW-1:0]   nx_slot,
  output logic             fs_out
);
  localparam int LW = FRM_W + 1;

  logic             run;
  logic [FRM_W-1:0] pos;
  logic [BIS_W-1:0] bis;
  logic [SIW-1:0]   slot;
  logic [5:0]       sw;
  logic             wrap;
  logic [LW-1:0]    flen, win, refp;
  logic             fs_lvl;

  assign sw   = slot_bits(cfg_slot_size, cfg_data_size);
  assign wrap = !run || (pos == cfg_frame_len_m1);

  always_comb begin
    nx_pos = wrap ? '0 : pos + 1'b1;
    if (wrap) begin
      nx_bis  = '0;
      nx_slot = '0;
    end else if (6'(bis) == sw - 6'd1) begin
      nx_bis  = '0;
      nx_slot = (slot == SIW'(SLOTS)) ? slot : slot + 1'b1;
    end else begin
      nx_bis  = bis + 1'b1;
      nx_slot = slot;
    end
  end

  // sync window evaluated on the position about to be driven
  always_comb begin
    flen = LW'(cfg_frame_len_m1) + 1'b1;
    win  = cfg_fs_chan_id ? (flen >> 1) : LW'(cfg_fs_width_m1) + 1'b1;
    if (cfg_fs_early)
      refp = (nx_pos == cfg_frame_len_m1) ? '0 : LW'(nx_pos) + 1'b1;
    else
      refp = LW'(nx_pos);
    fs_lvl = (refp < win) ? cfg_fs_active_high : !cfg_fs_active_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      pos    <= '0;
      bis    <= '0;
      slot   <= '0;
      fs_out <= 1'b1;
    end else if (!enable) begin
      run    <= 1'b0;
      fs_out <= !cfg_fs_active_high;
    end else if (tick) begin
      run    <= 1'b1;
      pos    <= nx_pos;
      bis    <= nx_bis;
      slot   <= nx_slot;
      fs_out <= fs_lvl;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && run && pos == cfg_frame_len_m1) |=> (pos == '0)); // R2

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(pos)); // R2

  AST_FIRST_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !run) |=> (pos == '0 && run)); // R2
endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath
  import tdm_tx_pkg::*;
#(
  parameter int SMP_W = 32,
  parameter int SLOTS = 16,
  parameter int BIS_W = 5,
  parameter int SIW   = 5,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [BIS_W-1:0] nx_bis,
  input  logic [SIW-1:0]   nx_slot,
  input  logic [CNT_W-1:0] cfg_slot_cnt_m1,
  input  logic [SLOTS-1:0] cfg_slot_mask,
  input  logic [2:0]       cfg_data_size,
  input  logic [BIS_W-1:0] cfg_first_bit,
  input  logic             cfg_msb_first,
  input  logic             cfg_tristate_idle,
  input  logic             cfg_mute,
  input  logic             cfg_mute_last,
  input  logic             s_valid,
  input  logic [SMP_W-1:0] s_data,
  input  logic             underrun_clr,
  output logic             s_ready,
  output logic             sd_out,
  output logic             sd_oe,
  output logic             underrun
);
  localparam int IDX_W = $clog2(SMP_W);

  logic [SMP_W-1:0] cur, last, fetch, smp_nx;
  logic             slot_on, load, in_data, bit_val, miss;
  logic [5:0]       dbits, kk;
  logic [IDX_W-1:0] idx;

  assign slot_on = (nx_slot <= SIW'(cfg_slot_cnt_m1)) && cfg_slot_mask[nx_slot[SIW-2:0]];
  assign load    = tick && slot_on && (nx_bis == '0);
  assign s_ready = load && !cfg_mute;
  assign miss    = load && !cfg_mute && !s_valid;

  always_comb begin
    if (cfg_mute)     fetch = cfg_mute_last ? last : '0;
    else if (s_valid) fetch = s_data;
    else              fetch = '0;
    smp_nx  = load ? fetch : cur;
    dbits   = data_bits(cfg_data_size);
    kk      = 6'(nx_bis) - 6'(cfg_first_bit);
    in_data = (nx_bis >= cfg_first_bit) && (kk < dbits);
    idx     = IDX_W'(cfg_msb_first ? (dbits - 6'd1 - kk) : kk);
    bit_val = smp_nx[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
      cur    <= '0;
      last   <= '0;
    end else if (!enable) begin
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else if (tick) begin
      sd_out <= slot_on && in_data && bit_val;
      sd_oe  <= slot_on || !cfg_tristate_idle;
      cur    <= smp_nx;
      if (load && !cfg_mute) last <= fetch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            underrun <= 1'b0;
    else if (miss)         underrun <= 1'b1;
    else if (underrun_clr) underrun <= 1'b0;
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun); // R11

  AST_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out); // R9

  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sd_oe && !sd_out)); // R12

  AST_MUTE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mute |-> !s_ready); // R10
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8,
  parameter int FSW_W = 7,
  parameter int SLOTS = 16,
  parameter int SMP_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [DIV_W-1:0]         cfg_bclk_div,
  input  logic [FRM_W-1:0]         cfg_frame_len_m1,
  input  logic [FSW_W-1:0]         cfg_fs_width_m1,
  input  logic                     cfg_fs_early,
  input  logic                     cfg_fs_active_high,
  input  logic                     cfg_fs_chan_id,
  input  logic [$clog2(SLOTS)-1:0] cfg_slot_cnt_m1,
  input  logic [SLOTS-1:0]         cfg_slot_mask,
  input  logic [1:0]               cfg_slot_size,
  input  logic [2:0]               cfg_data_size,
  input  logic [$clog2(SMP_W)-1:0] cfg_first_bit,
  input  logic                     cfg_msb_first,
  input  logic                     cfg_tristate_idle,
  input  logic                     cfg_mute,
  input  logic                     cfg_mute_last,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic [SMP_W-1:0]         s_data,
  input  logic                     underrun_clr,
  output logic                     bclk_en,
  output logic                     fs_out,
  output logic                     sd_out,
  output logic                     sd_oe,
  output logic                     underrun
);
  localparam int CNT_W = $clog2(SLOTS);
  localparam int SIW   = CNT_W + 1;
  localparam int BIS_W = $clog2(SMP_W);

  logic [FRM_W-1:0] nx_pos;
  logic [BIS_W-1:0] nx_bis;
  logic [SIW-1:0]   nx_slot;

  tdm_tx_bclk #(.DIV_W(DIV_W)) u_bclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .cfg_div (cfg_bclk_div),
    .bclk_en (bclk_en)
  );

  tdm_tx_timer #(
    .FRM_W(FRM_W), .FSW_W(FSW_W), .SLOTS(SLOTS), .BIS_W(BIS_W), .SIW(SIW)
  ) u_timer (
    .clk                (clk),
    .rst_n              (rst_n),
    .enable             (enable),
    .tick               (bclk_en),
    .cfg_frame_len_m1   (cfg_frame_len_m1),
    .cfg_fs_width_m1    (cfg_fs_width_m1),
    .cfg_fs_early       (cfg_fs_early),
    .cfg_fs_active_high (cfg_fs_active_high),
    .cfg_fs_chan_id     (cfg_fs_chan_id),
    .cfg_slot_size      (cfg_slot_size),
    .cfg_data_size      (cfg_data_size),
    .nx_pos             (nx_pos),
    .nx_bis             (nx_bis),
    .nx_slot            (nx_slot),
    .fs_out             (fs_out)
  );

  tdm_tx_datapath #(
    .SMP_W(SMP_W), .SLOTS(SLOTS), .BIS_W(BIS_W), .SIW(SIW), .CNT_W(CNT_W)
  ) u_data (
    .clk               (clk),
    .rst_n             (rst_n),
    .enable            (enable),
    .tick              (bclk_en),
    .nx_bis            (nx_bis),
    .nx_slot           (nx_slot),
    .cfg_slot_cnt_m1   (cfg_slot_cnt_m1),
    .cfg_slot_mask     (cfg_slot_mask),
    .cfg_data_size     (cfg_data_size),
    .cfg_first_bit     (cfg_first_bit),
    .cfg_msb_first     (cfg_msb_first),
    .cfg_tristate_idle (cfg_tristate_idle),
    .cfg_mute          (cfg_mute),
    .cfg_mute_last     (cfg_mute_last),
    .s_valid           (s_valid),
    .s_data            (s_data),
    .underrun_clr      (underrun_clr),
    .s_ready           (s_ready),
    .sd_out            (sd_out),
    .sd_oe             (sd_oe),
    .underrun          (underrun)
  );

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bclk_en); // R8

  AST_FRAME_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_en && nx_pos == '0 && !cfg_fs_early) |=> (fs_out == cfg_fs_active_high)); // R3
endmodule

// File: tb/tdm_frame_tx_tb_top.sv
module tdm_frame_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  cfg_bclk_div = 8'd1;
  logic [7:0]  cfg_frame_len_m1 = 8'd31;
  logic [6:0]  cfg_fs_width_m1 = 7'd15;
  logic        cfg_fs_early = 1'b1;
  logic        cfg_fs_active_high = 1'b0;
  logic        cfg_fs_chan_id = 1'b1;
  logic [3:0]  cfg_slot_cnt_m1 = 4'd1;
  logic [15:0] cfg_slot_mask = 16'h0003;
  logic [1:0]  cfg_slot_size = 2'd0;
  logic [2:0]  cfg_data_size = 3'd2;
  logic [4:0]  cfg_first_bit = 5'd0;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_tristate_idle = 1'b0;
  logic        cfg_mute = 1'b0;
  logic        cfg_mute_last = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        underrun_clr = 1'b0;
  logic        s_ready, bclk_en, fs_out, sd_out, sd_oe, underrun;

  always #2 clk = ~clk;

  tdm_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_bclk_div(cfg_bclk_div),
    .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_fs_width_m1(cfg_fs_width_m1),
    .cfg_fs_early(cfg_fs_early), .cfg_fs_active_high(cfg_fs_active_high),
    .cfg_fs_chan_id(cfg_fs_chan_id), .cfg_slot_cnt_m1(cfg_slot_cnt_m1),
    .cfg_slot_mask(cfg_slot_mask), .cfg_slot_size(cfg_slot_size),
    .cfg_data_size(cfg_data_size), .cfg_first_bit(cfg_first_bit),
    .cfg_msb_first(cfg_msb_first), .cfg_tristate_idle(cfg_tristate_idle),
    .cfg_mute(cfg_mute), .cfg_mute_last(cfg_mute_last), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .underrun_clr(underrun_clr),
    .bclk_en(bclk_en), .fs_out(fs_out), .sd_out(sd_out), .sd_oe(sd_oe),
    .underrun(underrun)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  function automatic int dbits(input int c);
    case (c)
      0: return 8; 1: return 10; 2: return 16; 3: return 20; 4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int sbits(input int s, input int c);
    if (s == 0) return dbits(c);
    if (s == 1) return 16;
    return 32;
  endfunction

  // ---------------- sample source ----------------
  logic [31:0] q[$];
  bit hs_n = 1'b0;

  always @(posedge clk) begin
    #1;
    if (hs_n) begin
      void'(q.pop_front());
      hs_n = 1'b0;
    end
    s_valid = (q.size() > 0);
    s_data  = (q.size() > 0) ? q[0] : 32'h0;
  end

  // ---------------- behavioural frame model ----------------
  int m_div = 0, m_pos = 0;
  bit m_run = 0, m_fs = 1, m_sd = 0, m_oe = 0, m_ur = 0;
  logic [31:0] m_cur = '0, m_last = '0;

  always @(negedge clk) begin : model
    bit tick, active, start, exp_rdy, miss;
    int p, L, sw, slot, bis, db, k, w, qv;
    if (!rst_n || done) begin
      if (!rst_n) begin
        m_div = 0; m_pos = 0; m_run = 0; m_fs = 1; m_sd = 0; m_oe = 0; m_ur = 0;
        m_cur = '0; m_last = '0;
      end
    end else begin
      L    = int'(cfg_frame_len_m1) + 1;
      tick = enable && (m_div == int'(cfg_bclk_div));
      p    = m_run ? ((m_pos == L - 1) ? 0 : m_pos + 1) : 0;
      sw   = sbits(int'(cfg_slot_size), int'(cfg_data_size));
      slot = p / sw;
      bis  = p % sw;
      active  = (slot <= int'(cfg_slot_cnt_m1)) && cfg_slot_mask[slot];
      start   = tick && active && (bis == 0);
      exp_rdy = start && !cfg_mute;
      miss    = exp_rdy && !s_valid;

      chk("R1", "bclk_en", 32'(bclk_en), 32'(tick));
      chk("R8", "s_ready", 32'(s_ready), 32'(exp_rdy));
      chk("R2 R3 R4 R5", "fs_out", 32'(fs_out), 32'(m_fs));
      chk("R6 R7 R10", "sd_out", 32'(sd_out), 32'(m_sd));
      chk("R9 R12", "sd_oe", 32'(sd_oe), 32'(m_oe));
      chk("R11", "underrun", 32'(underrun), 32'(m_ur));

      if (s_valid && s_ready) hs_n = 1'b1;

      if (!enable) begin
        m_run = 0; m_fs = !cfg_fs_active_high; m_sd = 0; m_oe = 0;
      end else if (tick) begin
        if (start) begin
          if (cfg_mute)     m_cur = cfg_mute_last ? m_last : 32'h0;
          else if (s_valid) m_cur = s_data;
          else              m_cur = 32'h0;
          if (!cfg_mute) m_last = m_cur;
        end
        db = dbits(int'(cfg_data_size));
        k  = bis - int'(cfg_first_bit);
        if (active && k >= 0 && k < db)
          m_sd = cfg_msb_first ? m_cur[db - 1 - k] : m_cur[k];
        else
          m_sd = 0;
        m_oe = active || !cfg_tristate_idle;
        w  = cfg_fs_chan_id ? L / 2 : int'(cfg_fs_width_m1) + 1;
        qv = cfg_fs_early ? ((p == L - 1) ? 0 : p + 1) : p;
        m_fs  = (qv < w) ? cfg_fs_active_high : !cfg_fs_active_high;
        m_pos = p;
        m_run = 1;
      end
      if (miss)              m_ur = 1;
      else if (underrun_clr) m_ur = 0;
      m_div = (!enable || tick) ? 0 : m_div + 1;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic feed(input int n, input logic [31:0] seed);
    for (int i = 0; i < n; i++) q.push_back((32'h9E3779B9 * (i + 1)) ^ seed);
  endtask

  task automatic play(input int cycles);
    enable = 1'b1;
    step(cycles);
    enable = 1'b0;
    step(4);
    q.delete();
    step(2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    report();
    $finish;
  end

  initial begin : stim
    step(5);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12: reset state
    chk("R12", "reset fs_out", 32'(fs_out), 32'h1);
    chk("R12", "reset sd_oe", 32'(sd_oe), 32'h0);
    chk("R12", "reset sd_out", 32'(sd_out), 32'h0);
    chk("R12", "reset underrun", 32'(underrun), 32'h0);
    chk("R1", "reset bclk_en", 32'(bclk_en), 32'h0);
    step(1);

    // A: stereo 16-bit, sync one bit early, R4 channel identification, LSB first
    feed(20, 32'h1234_5678);
    step(2);
    play(256);
    chk("R11", "no underrun with data ready", 32'(underrun), 32'h0);

    // B: R3 start-of-frame active-high sync, 32-bit slots, 24-bit data, R7 MSB first, R9 tri-state
    cfg_frame_len_m1 = 8'd127; cfg_fs_width_m1 = 7'd2; cfg_fs_early = 1'b0;
    cfg_fs_active_high = 1'b1; cfg_fs_chan_id = 1'b0; cfg_slot_cnt_m1 = 4'd3;
    cfg_slot_mask = 16'b1010; cfg_slot_size = 2'd2; cfg_data_size = 3'd4;
    cfg_first_bit = 5'd4; cfg_msb_first = 1'b1; cfg_tristate_idle = 1'b1;
    cfg_bclk_div = 8'd0;
    feed(20, 32'hA5A5_0F0F);
    step(2);
    play(512);

    // C: R11 underrun with an empty source, then sticky hold and clear
    play(100);
    chk("R11", "underrun set", 32'(underrun), 32'h1);
    step(10);
    chk("R11", "underrun held", 32'(underrun), 32'h1);
    underrun_clr = 1'b1;
    step(1);
    underrun_clr = 1'b0;
    @(negedge clk); #1;
    chk("R11", "underrun cleared", 32'(underrun), 32'h0);
    step(1);

    // D: 16-bit slots, 10-bit data clipped at slot end, slots past count silent, R10 mute
    cfg_frame_len_m1 = 8'd63; cfg_fs_width_m1 = 7'd0; cfg_fs_active_high = 1'b0;
    cfg_slot_cnt_m1 = 4'd1; cfg_slot_mask = 16'h000F; cfg_slot_size = 2'd1;
    cfg_data_size = 3'd1; cfg_first_bit = 5'd7; cfg_msb_first = 1'b0;
    cfg_bclk_div = 8'd2;
    feed(12, 32'h0000_03FF);
    step(2);
    enable = 1'b1;
    step(192);
    cfg_mute = 1'b1; cfg_mute_last = 1'b1;   // R10 repeat last
    step(384);
    cfg_mute_last = 1'b0;                    // R10 zeros
    step(192);
    cfg_mute = 1'b0;
    step(192);
    enable = 1'b0;
    step(4);
    q.delete();
    step(2);

    // E: 8-bit data-sized slots, offset clips data, R5 early sync, channel id, gaps
    cfg_frame_len_m1 = 8'd39; cfg_fs_early = 1'b1; cfg_fs_active_high = 1'b1;
    cfg_fs_chan_id = 1'b1; cfg_slot_cnt_m1 = 4'd4; cfg_slot_mask = 16'b10111;
    cfg_slot_size = 2'd0; cfg_data_size = 3'd0; cfg_first_bit = 5'd3;
    cfg_msb_first = 1'b1; cfg_tristate_idle = 1'b0; cfg_bclk_div = 8'd0;
    underrun_clr = 1'b1;
    step(1);
    underrun_clr = 1'b0;
    feed(9, 32'h00C3_5A96);
    step(2);
    play(200);

    done = 1'b1;
    report();
    $finish;
  end
endmodule